// File: doc/BRIEF.md
# Grouped Interrupt Combiner

The combiner gathers a large number of level-sensitive interrupt sources into a much smaller set of parent interrupt lines. Sources come in groups of eight. Each group drives one parent output. That output goes high one clock after any line of the group is both asserted and enabled, and it stays high for as long as such a line is held.

Software reaches the block through a plain memory-mapped port with byte addresses, a write strobe and combinational read data. Four groups share one 32-bit bank, and the banks sit 0x10 bytes apart. Each bank has three registers:
- a write-one-to-set enable register,
- a write-one-to-clear enable register,
- a read-only status register that shows the lines which are both enabled and asserted.

This lets an interrupt handler find the pending line within its group from a single read. The number of groups is a parameter, and the default is 20 groups (160 lines in 5 banks). When the group count is not a multiple of four, the last bank is only partly populated.

Top module: `irq_combiner`

## Requirements
- R1: After reset, every enable bit is 0, every parent output is 0, and every register read returns 0.
- R2: A write to bank offset 0x0 sets each enable bit whose write-data bit is 1 and leaves the bits written with 0 unchanged.
- R3: A write to bank offset 0x4 clears each enable bit whose write-data bit is 1 and leaves the bits written with 0 unchanged.
- R4: A read of bank offset 0xC returns the bitwise AND of that bank's enable mask and its input lines in the same cycle. A write to 0xC changes no state.
- R5: A read of bank offset 0x0 or of bank offset 0x4 returns the current enable mask of that bank.
- R6: Input irq_in[8*g+k] is line k of group g. It sits in bank g/4 at bit 8*(g%4)+k, and bank b occupies byte addresses 0x10*b to 0x10*b+0xF.
- R7: irq_out[g] is high exactly when, at the previous clock edge, at least one line of group g was both enabled and high. This is one cycle of latency.
- R8: The inputs are levels. A parent output stays high while an enabled source is held high, and it falls one cycle after the last such source drops or is disabled.
- R9: Reads of undefined addresses return 0, and writes to them change no state. Undefined addresses are offset 0x8, offsets that are not 0x0, 0x4 or 0xC, and banks at or above the bank count.
- R10: In a partly populated last bank, the bits of groups at or above the group count always read 0 and cannot be set.
- R11: Accesses take effect one per cycle, in the order they are given. Setting a bit and then clearing it in the next cycle leaves it clear. Clearing a bit and then setting it leaves it set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, acted on at the clock edge |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe, one write per asserted cycle |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq_in | input | NUM_GROUPS*8 | Level-sensitive interrupt sources |
| irq_out | output | NUM_GROUPS | One registered parent interrupt per group |

## Verification
The bench builds the block with NUM_GROUPS = 6 and ADDR_W = 8. This gives one full bank and one bank with only two of its four group slots populated, so the unpopulated enable bits of the partial bank can be written and checked. With an 8-bit address, the banks above the second one are still addressable and must read as holes. A behavioural model tracks every enable bit and parent output and is compared with both outputs on every clock, under directed accesses and under a long run of random writes, reads and input levels.

// File: rtl/irq_combiner_pkg.sv
package irq_combiner_pkg;

  localparam int LINES_PER_GROUP = 8;
  localparam int GROUPS_PER_BANK = 4;
  localparam int BANK_BITS       = 32;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_SET  = 2'd1,
    ACC_CLR  = 2'd2,
    ACC_STAT = 2'd3
  } acc_kind_t;

  // Bits of bank 'bank' that belong to groups which exist.
  function automatic logic [BANK_BITS-1:0] bank_valid_mask(input int bank, input int groups);
    logic [BANK_BITS-1:0] m;
    m = '0;
    for (int i = 0; i < GROUPS_PER_BANK; i++) begin
      if (bank * GROUPS_PER_BANK + i < groups)
        m[i*LINES_PER_GROUP +: LINES_PER_GROUP] = '1;
    end
    return m;
  endfunction

  // Register kind selected by the low nibble of the byte address.
  function automatic acc_kind_t offset_kind(input logic [3:0] off);
    case (off)
      4'h0:    return ACC_SET;
      4'h4:    return ACC_CLR;
      4'hC:    return ACC_STAT;
      default: return ACC_NONE;
    endcase
  endfunction

  function automatic logic group_pending(input logic [LINES_PER_GROUP-1:0] en,
                                         input logic [LINES_PER_GROUP-1:0] lines);
    return |(en & lines);
  endfunction

endpackage

// File: rtl/irq_comb_decode.sv
module irq_comb_decode
  import irq_combiner_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_BANKS = 5
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr,
  output logic [NUM_BANKS-1:0] bank_hit,
  output acc_kind_t            kind,
  output logic [NUM_BANKS-1:0] set_hit,
  output logic [NUM_BANKS-1:0] clr_hit,
  output logic                 addr_ok
);

  localparam int UW = ADDR_W - 4;

  logic [UW-1:0] upper;
  acc_kind_t     raw_kind;

  assign upper    = addr[ADDR_W-1:4];
  assign raw_kind = offset_kind(addr[3:0]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
    assign bank_hit[b] = (upper == UW'(b));
  end

  assign addr_ok = (|bank_hit) && (raw_kind != ACC_NONE);
  assign kind    = addr_ok ? raw_kind : ACC_NONE;
  assign set_hit = (wr && kind == ACC_SET) ? bank_hit : '0;
  assign clr_hit = (wr && kind == ACC_CLR) ? bank_hit : '0;

endmodule

// File: rtl/irq_comb_bank.sv
module irq_comb_bank
  import irq_combiner_pkg::*;
#(
  parameter logic [BANK_BITS-1:0] VALID_MASK = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_hit,
  input  logic                 clr_hit,
  input  logic [BANK_BITS-1:0] wdata,
  input  logic [BANK_BITS-1:0] lines,
  output logic [BANK_BITS-1:0] en,
  output logic [BANK_BITS-1:0] status
);

  logic [BANK_BITS-1:0] set_bits;
  logic [BANK_BITS-1:0] clr_bits;
  logic [BANK_BITS-1:0] en_next;

  assign set_bits = set_hit ? wdata : '0;
  assign clr_bits = clr_hit ? wdata : '0;
  assign en_next  = ((en | set_bits) & ~clr_bits) & VALID_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) en <= '0;
    else        en <= en_next;
  end

  assign status = en & lines;

endmodule

// File: rtl/irq_comb_group.sv
module irq_comb_group
  import irq_combiner_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LINES_PER_GROUP-1:0] en,
  input  logic [LINES_PER_GROUP-1:0] lines,
  output logic                       irq
);

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= group_pending(en, lines);
  end

endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
  import irq_combiner_pkg::*;
#(
  parameter int NUM_GROUPS = 20,
  parameter int ADDR_W     = 12
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [ADDR_W-1:0]                     reg_addr,
  input  logic [31:0]                           reg_wdata,
  input  logic                                  reg_wr,
  output logic [31:0]                           reg_rdata,
  input  logic [NUM_GROUPS*LINES_PER_GROUP-1:0] irq_in,
  output logic [NUM_GROUPS-1:0]                 irq_out
);

  localparam int NUM_LINES = NUM_GROUPS * LINES_PER_GROUP;
  localparam int NUM_BANKS = (NUM_GROUPS + GROUPS_PER_BANK - 1) / GROUPS_PER_BANK;
  localparam int PAD_W     = NUM_BANKS * BANK_BITS;

  logic [NUM_BANKS-1:0] bank_hit;
  logic [NUM_BANKS-1:0] set_hit;
  logic [NUM_BANKS-1:0] clr_hit;
  acc_kind_t            kind;
  logic                 addr_ok;
  logic [PAD_W-1:0]     irq_pad;
  logic [PAD_W-1:0]     en_flat;
  logic [PAD_W-1:0]     stat_flat;

  irq_comb_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_decode (
    .addr     (reg_addr),
    .wr       (reg_wr),
    .bank_hit (bank_hit),
    .kind     (kind),
    .set_hit  (set_hit),
    .clr_hit  (clr_hit),
    .addr_ok  (addr_ok)
  );

  always_comb begin
    irq_pad                = '0;
    irq_pad[NUM_LINES-1:0] = irq_in;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    irq_comb_bank #(.VALID_MASK(bank_valid_mask(b, NUM_GROUPS))) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_hit (set_hit[b]),
      .clr_hit (clr_hit[b]),
      .wdata   (reg_wdata),
      .lines   (irq_pad[b*BANK_BITS +: BANK_BITS]),
      .en      (en_flat[b*BANK_BITS +: BANK_BITS]),
      .status  (stat_flat[b*BANK_BITS +: BANK_BITS])
    );
  end

  // Group g occupies flat bits 8*g..8*g+7 because each bank holds four groups.
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    irq_comb_group u_group (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en_flat[g*LINES_PER_GROUP +: LINES_PER_GROUP]),
      .lines (irq_in[g*LINES_PER_GROUP +: LINES_PER_GROUP]),
      .irq   (irq_out[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) begin
        case (kind)
          ACC_SET, ACC_CLR: reg_rdata = en_flat[b*BANK_BITS +: BANK_BITS];
          ACC_STAT:         reg_rdata = stat_flat[b*BANK_BITS +: BANK_BITS];
          default:          reg_rdata = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/irq_combiner_chk.sv
module irq_combiner_chk
  import irq_combiner_pkg::*;
#(
  parameter int NUM_GROUPS = 20,
  parameter int NUM_BANKS  = 5
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic [31:0]                           reg_rdata,
  input logic [31:0]                           reg_wdata,
  input logic [NUM_GROUPS*LINES_PER_GROUP-1:0] irq_in,
  input logic [NUM_GROUPS-1:0]                 irq_out,
  input logic [NUM_BANKS*BANK_BITS-1:0]        en_flat,
  input logic [NUM_BANKS-1:0]                  set_hit,
  input logic [NUM_BANKS-1:0]                  clr_hit,
  input logic                                  addr_ok
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
    localparam logic [BANK_BITS-1:0] VM = bank_valid_mask(b, NUM_GROUPS);

    assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      set_hit[b] |=> ((en_flat[b*BANK_BITS +: BANK_BITS] & $past(reg_wdata & VM))
                      == $past(reg_wdata & VM)));

    assert_clear_sticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_hit[b] |=> ((en_flat[b*BANK_BITS +: BANK_BITS] & $past(reg_wdata)) == '0));

    assert_idle_bank_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_hit[b] && !clr_hit[b]) |=> $stable(en_flat[b*BANK_BITS +: BANK_BITS]));

    assert_empty_slots_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (en_flat[b*BANK_BITS +: BANK_BITS] & ~VM) == '0);
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp_chk
    assert_out_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out[g] == $past(|(en_flat[g*LINES_PER_GROUP +: LINES_PER_GROUP]
                            & irq_in[g*LINES_PER_GROUP +: LINES_PER_GROUP])));
  end

  assert_hole_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_ok |-> reg_rdata == '0);

  assert_single_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({set_hit, clr_hit}) <= 1);

endmodule

bind irq_combiner irq_combiner_chk #(.NUM_GROUPS(NUM_GROUPS), .NUM_BANKS(NUM_BANKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_rdata (reg_rdata),
  .reg_wdata (reg_wdata),
  .irq_in    (irq_in),
  .irq_out   (irq_out),
  .en_flat   (en_flat),
  .set_hit   (set_hit),
  .clr_hit   (clr_hit),
  .addr_ok   (addr_ok)
);

// File: tb/test_irq_combiner.sv
module test_irq_combiner;

  localparam int NG = 6;
  localparam int NL = NG * 8;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic          reg_wr = 1'b0;
  logic [31:0]   reg_rdata;
  logic [NL-1:0] irq_in = '0;
  logic [NG-1:0] irq_out;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;

  // Behavioural model: enable words of the two banks and expected outputs.
  logic [31:0]   m_en [2];
  logic [NG-1:0] m_out;

  always #10 clk = ~clk;

  irq_combiner #(.NUM_GROUPS(NG), .ADDR_W(AW)) i_irq_combiner (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata),
    .irq_in    (irq_in),
    .irq_out   (irq_out)
  );

  // Populated bits per bank: bank 0 holds groups 0-3, bank 1 only groups 4-5.
  function automatic logic [31:0] populated(input int bank);
    if (bank == 0) return 32'hFFFF_FFFF;
    return 32'h0000_FFFF;
  endfunction

  function automatic logic [31:0] model_read(input logic [AW-1:0] a);
    int bank;
    int off;
    logic [31:0] st;
    bank = int'(a) / 16;
    off  = int'(a) % 16;
    if (bank >= 2) return 32'h0;
    if (off == 0 || off == 4) return m_en[bank];
    if (off == 12) begin
      st = '0;
      for (int k = 0; k < 32; k++)
        if (bank * 32 + k < NL && irq_in[bank*32 + k] && m_en[bank][k]) st[k] = 1'b1;
      return st;
    end
    return 32'h0;
  endfunction

  function automatic string read_tag(input logic [AW-1:0] a);
    int off;
    off = int'(a) % 16;
    if (int'(a) / 16 >= 2) return "R9";
    if (off == 12) return "R4";
    if (off == 0 || off == 4) return "R5";
    return "R9";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R7", 32'(irq_out), 32'(m_out));
    chk(read_tag(reg_addr), reg_rdata, model_read(reg_addr));
  endtask

  // One clock: model the edge from the present inputs, then compare.
  task automatic step();
    logic [31:0]   n_en [2];
    logic [NG-1:0] n_out;
    int bank;
    int off;
    n_out = '0;
    for (int l = 0; l < NL; l++)
      if (irq_in[l] && m_en[l/32][l%32]) n_out[l/8] = 1'b1;
    n_en[0] = m_en[0];
    n_en[1] = m_en[1];
    bank = int'(reg_addr) / 16;
    off  = int'(reg_addr) % 16;
    if (reg_wr && bank < 2) begin
      if (off == 0) n_en[bank] = m_en[bank] | (reg_wdata & populated(bank));
      if (off == 4) n_en[bank] = m_en[bank] & ~reg_wdata;
    end
    @(posedge clk);
    m_en[0] = n_en[0];
    m_en[1] = n_en[1];
    m_out   = n_out;
    #4;
    compare_all();
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    m_en[0] = '0; m_en[1] = '0; m_out = '0;
    repeat (3) @(posedge clk);
    #4;
    // R1: reset state
    chk("R1", 32'(irq_out), 32'h0);
    rd(8'h00, "R1", 32'h0);
    rd(8'h1C, "R1", 32'h0);
    rst_n = 1'b1;
    step();
    irq_in = '1;
    step();
    chk("R1", 32'(irq_out), 32'h0);
    irq_in = '0;

    // R2: set in bank 0, group 0 lines, zero bits untouched
    wr(8'h00, 32'h0000_0081);
    wr(8'h00, 32'h0000_0002);
    rd(8'h00, "R2", 32'h0000_0083);
    rd(8'h04, "R5", 32'h0000_0083);
    irq_in[7] = 1'b1;
    step();
    chk("R7", 32'(irq_out), 32'h1);

    // R4: status read, and a write to status is ignored
    rd(8'h0C, "R4", 32'h0000_0080);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h00, "R4", 32'h0000_0083);

    // R8: held level keeps output, release drops it one cycle later
    step();
    chk("R8", 32'(irq_out), 32'h1);
    irq_in[7] = 1'b0;
    step();
    chk("R8", 32'(irq_out), 32'h0);
    irq_in[0] = 1'b1;
    step();
    chk("R8", 32'(irq_out), 32'h1);

    // R3: clear line 0 only
    wr(8'h04, 32'h0000_0001);
    rd(8'h00, "R3", 32'h0000_0082);
    step();
    chk("R3", 32'(irq_out), 32'h0);
    irq_in = '0;

    // R10: partial bank keeps only groups 4 and 5
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, "R10", 32'h0000_FFFF);

    // R6: one line per group maps to one output
    wr(8'h00, 32'hFFFF_FFFF);
    for (int g = 0; g < NG; g++) begin
      irq_in = '0;
      irq_in[g*8 + (g % 8)] = 1'b1;
      step();
      step();
      chk("R6", 32'(irq_out), 32'(1 << g));
      rd(AW'(16 * (g / 4) + 12), "R6", 32'(1) << (8 * (g % 4) + (g % 8)));
    end
    irq_in = '0;

    // R9: holes read zero and do not change state
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    rd(8'h08, "R9", 32'h0);
    rd(8'h20, "R9", 32'h0);
    rd(8'h05, "R9", 32'h0);
    rd(8'h00, "R9", 32'hFFFF_FFFF);
    rd(8'h14, "R9", 32'h0000_FFFF);

    // R11: accesses in order
    wr(8'h14, 32'h0000_0100);
    wr(8'h10, 32'h0000_0100);
    rd(8'h10, "R11", 32'h0000_FFFF);
    wr(8'h10, 32'h0000_0200);
    wr(8'h14, 32'h0000_0200);
    rd(8'h10, "R11", 32'h0000_FDFF);

    // Random traffic, compared on every clock
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      irq_in    = {$urandom, $urandom};
      reg_addr  = AW'(r[7:0] & 8'h3C);
      reg_wdata = $urandom;
      reg_wr    = r[8] & r[9];
      step();
    end
    reg_wr = 1'b0;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule